// File: doc/BRIEF.md
# Bus-Port Parity Generator and Checker

This block computes parity over a group of nine data lines and shares one parity pin with a bus. One control input picks the role of that pin. With the control low the unit generates: it drives its computed parity bit onto the bus and holds its local error flag inactive. With the control high the unit checks: it releases the pin, samples the parity bit another agent placed on the bus, and pulls its active-low error flag low if that bit disagrees with the data. A sense input chooses odd or even parity.

The pin is modelled as three signals: a driven value, an output enable and a sampled value. Wider words are covered by cascading nine-input stages. Each stage after the first takes eight new data lines, and its ninth input is the parity bit of the stage before it. Interior stages always pass plain XOR parity along the chain. Only the final stage applies the selected sense and faces the bus pin. All logic is combinational.

Top module: `bus_parity_unit`

## Requirements
- R1: In odd sense (`even_sel` = 0), `parity_out` is 1 when an even number of the data bits are 1 and 0 when an odd number are 1, so that data plus parity holds an odd count of ones.
- R2: In even sense (`even_sel` = 1), `parity_out` is 1 exactly when an odd number of the data bits are 1.
- R3: While `check_en` is 0, `parity_oe` is 1 and `err_n` is 1 for every data pattern and every `parity_in` value.
- R4: While `check_en` is 1, `parity_oe` is 0.
- R5: While `check_en` is 1 in odd sense, `err_n` is 0 exactly when an even number of data bits are 1 and `parity_in` is 0, or when an odd number are 1 and `parity_in` is 1.
- R6: While `check_en` is 1 in even sense, `err_n` is 0 exactly when `parity_in` differs from the XOR of all data bits.
- R7: With `N_STAGES` stages the data word is 9 + 8*(`N_STAGES`-1) bits wide, and R1 to R6 hold over the whole word.
- R8: With all inputs at 0, `parity_out` is 1, `parity_oe` is 1 and `err_n` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| data_i | input | 9+8*(N_STAGES-1) | Data lines covered by the parity |
| check_en | input | 1 | 0: generate and drive the pin; 1: check against the pin |
| even_sel | input | 1 | 0: odd parity sense; 1: even parity sense |
| parity_in | input | 1 | Value sampled from the shared parity pin |
| parity_out | output | 1 | Generated parity bit for the pin |
| parity_oe | output | 1 | Drive enable for the parity pin |
| err_n | output | 1 | Active-low parity mismatch flag |

## Verification
Every output is a pure combinational function of the inputs, so each result is due in the same cycle as its stimulus, with no register in the path. The driver task changes the inputs just after a rising edge and queues the expected values. The monitor pops and compares them at the following falling edge, half a period later, when the logic has settled and before the next input change. A single-stage instance is swept through all 512 data patterns in both senses and with both pin values, in both roles. A three-stage instance receives pseudo-random 25-bit words in the same cycles.

// File: rtl/bus_parity_pkg.sv
package bus_parity_pkg;

   localparam int unsigned STAGE_INPUTS = 9;
   localparam int unsigned STAGE_NEW    = STAGE_INPUTS - 1;

   typedef enum logic {
      SENSE_ODD  = 1'b0,
      SENSE_EVEN = 1'b1
   } sense_t;

   function automatic int unsigned word_width(input int unsigned stages);
      return STAGE_INPUTS + STAGE_NEW * (stages - 1);
   endfunction

endpackage

// File: rtl/bpu_xor_tree.sv
module bpu_xor_tree #(
   parameter int unsigned W        = 9,
   parameter bit          BALANCED = 1'b1
) (
   input  logic [W-1:0] bits,
   output logic         odd
);

   if (W < 2) begin : g_bad_w
      $error("bpu_xor_tree: W must be at least 2");
   end

   if (BALANCED) begin : g_balanced
      localparam int unsigned LV = $clog2(W);
      localparam int unsigned P  = 1 << LV;
      logic [2*P-1:1] node;
      for (genvar i = 0; i < P; i++) begin : g_leaf
         if (i < W) begin : g_used
            assign node[P+i] = bits[i];
         end else begin : g_pad
            assign node[P+i] = 1'b0;
         end
      end
      for (genvar i = 1; i < P; i++) begin : g_node
         assign node[i] = node[2*i] ^ node[2*i+1];
      end
      assign odd = node[1];
   end else begin : g_linear
      logic [W-1:0] acc;
      assign acc[0] = bits[0];
      for (genvar i = 1; i < W; i++) begin : g_step
         assign acc[i] = acc[i-1] ^ bits[i];
      end
      assign odd = acc[W-1];
   end

endmodule

// File: rtl/bpu_stage.sv
module bpu_stage
   import bus_parity_pkg::*;
#(
   parameter bit BALANCED = 1'b1
) (
   input  logic [STAGE_INPUTS-1:0] d,
   input  sense_t                  sense,
   output logic                    p
);

   logic x;

   bpu_xor_tree #(.W(STAGE_INPUTS), .BALANCED(BALANCED)) u_tree (
      .bits (d),
      .odd  (x)
   );

   // odd sense: bit makes the total count odd; even sense: plain XOR
   assign p = x ^ (sense == SENSE_ODD);

endmodule

// File: rtl/bpu_port_ctl.sv
module bpu_port_ctl (
   input  logic gen_bit,
   input  logic check_en,
   input  logic parity_in,
   output logic parity_out,
   output logic parity_oe,
   output logic err_n
);

   assign parity_out = gen_bit;
   assign parity_oe  = ~check_en;
   assign err_n      = ~(check_en & (parity_in ^ gen_bit));

endmodule

// File: rtl/bus_parity_unit.sv
module bus_parity_unit
   import bus_parity_pkg::*;
#(
   parameter int unsigned N_STAGES = 2,
   parameter bit          BALANCED = 1'b1
) (
   input  logic [word_width(N_STAGES)-1:0] data_i,
   input  logic                            check_en,
   input  logic                            even_sel,
   input  logic                            parity_in,
   output logic                            parity_out,
   output logic                            parity_oe,
   output logic                            err_n
);

   localparam int unsigned WORD_W = word_width(N_STAGES);

   if (N_STAGES < 1) begin : g_bad_n
      $error("bus_parity_unit: N_STAGES must be at least 1");
   end
   if (WORD_W != STAGE_INPUTS + STAGE_NEW * (N_STAGES - 1)) begin : g_bad_w
      $error("bus_parity_unit: word width mismatch");
   end

   logic [N_STAGES-1:0] link;

   for (genvar k = 0; k < N_STAGES; k++) begin : g_stage
      logic [STAGE_INPUTS-1:0] d_k;
      sense_t                  s_k;

      if (k == 0) begin : g_head
         assign d_k = data_i[STAGE_INPUTS-1:0];
      end else begin : g_tail
         assign d_k = {link[k-1], data_i[STAGE_INPUTS + STAGE_NEW*(k-1) +: STAGE_NEW]};
      end

      if (k == N_STAGES - 1) begin : g_last
         assign s_k = sense_t'(even_sel);
      end else begin : g_inner
         assign s_k = SENSE_EVEN;
      end

      bpu_stage #(.BALANCED(BALANCED)) u_stage (
         .d     (d_k),
         .sense (s_k),
         .p     (link[k])
      );
   end

   bpu_port_ctl u_port (
      .gen_bit    (link[N_STAGES-1]),
      .check_en   (check_en),
      .parity_in  (parity_in),
      .parity_out (parity_out),
      .parity_oe  (parity_oe),
      .err_n      (err_n)
   );

endmodule

// File: rtl/bus_parity_unit_chk.sv
module bus_parity_unit_chk #(
   parameter int unsigned W = 9
) (
   input logic [W-1:0] data_i,
   input logic         check_en,
   input logic         even_sel,
   input logic         parity_in,
   input logic         parity_out,
   input logic         parity_oe,
   input logic         err_n
);

   always_comb begin
      // R1 R2 R7
      parity_sense_chk: assert (^{data_i, parity_out} == ~even_sel)
         else $error("parity_out breaks selected sense");
      // R3
      gen_role_chk: assert (check_en || (parity_oe && err_n))
         else $error("generate role: pin not driven or error flagged");
      // R4
      check_release_chk: assert (!check_en || !parity_oe)
         else $error("check role: pin still driven");
      // R5 R6
      mismatch_chk: assert (!check_en || (err_n == ((^data_i ^ parity_in) == ~even_sel)))
         else $error("check role: error flag disagrees with bus bit");
   end

endmodule

bind bus_parity_unit bus_parity_unit_chk #(.W(WORD_W)) u_chk (
   .data_i     (data_i),
   .check_en   (check_en),
   .even_sel   (even_sel),
   .parity_in  (parity_in),
   .parity_out (parity_out),
   .parity_oe  (parity_oe),
   .err_n      (err_n)
);

// File: tb/bus_parity_unit_test.sv
module bus_parity_unit_test;

   localparam int CW = 25;

   logic clk = 1'b0;
   logic rst = 1'b1;
   always #4 clk = ~clk;

   logic [8:0]    d1;
   logic [CW-1:0] d3;
   logic ce, es, pin;
   logic p1, oe1, e1, p3, oe3, e3;

   bus_parity_unit #(.N_STAGES(1)) uut (
      .data_i(d1), .check_en(ce), .even_sel(es), .parity_in(pin),
      .parity_out(p1), .parity_oe(oe1), .err_n(e1));

   bus_parity_unit #(.N_STAGES(3), .BALANCED(1'b0)) uut_chain (
      .data_i(d3), .check_en(ce), .even_sel(es), .parity_in(pin),
      .parity_out(p3), .parity_oe(oe3), .err_n(e3));

   typedef struct {
      logic p1, e1, p3, e3, oe;
      logic [8:0] d;
      logic ce, es, pin;
   } item_t;

   item_t q[$];
   int checks = 0;
   int errors = 0;
   bit done = 0;

   function automatic logic exp_p(input int ones, input logic sense);
      return (ones % 2 == 1) ? sense : ~sense;
   endfunction

   task automatic drive(input logic [8:0] d, input logic [CW-1:0] dc,
                        input logic c, input logic s, input logic b);
      item_t it;
      @(posedge clk);
      #1;
      d1 = d; d3 = dc; ce = c; es = s; pin = b;
      it.d = d; it.ce = c; it.es = s; it.pin = b;
      it.p1 = exp_p($countones(d), s);
      it.p3 = exp_p($countones(dc), s);
      it.e1 = ~(c & (b != it.p1));
      it.e3 = ~(c & (b != it.p3));
      it.oe = ~c;
      q.push_back(it);
   endtask

   task automatic cmp(input logic act, input logic exp, input string what);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%b expected=%b", what, act, exp);
      end
   endtask

   always @(negedge clk) begin
      if (q.size() > 0) begin
         item_t it;
         it = q.pop_front();
         if (it.d == 9'd0 && it.ce == 1'b0 && it.es == 1'b0 && it.pin == 1'b0) begin
            cmp(p1,  1'b1, "R8 parity_out at all-zero inputs");
            cmp(oe1, 1'b1, "R8 parity_oe at all-zero inputs");
            cmp(e1,  1'b1, "R8 err_n at all-zero inputs");
         end
         cmp(p1, it.p1, it.es ? "R2 parity_out even sense" : "R1 parity_out odd sense");
         cmp(oe1, it.oe, it.ce ? "R4 parity_oe check role" : "R3 parity_oe generate role");
         if (!it.ce) cmp(e1, it.e1, "R3 err_n generate role");
         else cmp(e1, it.e1, it.es ? "R6 err_n even sense" : "R5 err_n odd sense");
         cmp(p3, it.p3, "R7 chain parity_out");
         cmp(oe3, it.oe, "R7 chain parity_oe");
         cmp(e3, it.e3, "R7 chain err_n");
      end
   end

   initial begin
      int cyc = 0;
      while (!done) begin
         @(posedge clk);
         cyc++;
         if (cyc > 20000) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=%0d expected<=20000 cycles", cyc);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
         end
      end
   end

   initial begin
      d1 = '0; d3 = '0; ce = 1'b0; es = 1'b0; pin = 1'b0;
      repeat (3) @(posedge clk);
      rst = 1'b0;
      // R8 reset state, all inputs at zero
      drive(9'd0, '0, 1'b0, 1'b0, 1'b0);
      for (int s = 0; s < 2; s++) begin
         for (int v = 0; v < 512; v++) begin
            logic [CW-1:0] r;
            r = CW'($urandom);
            // R1 R2 R3: generate role, pin value must be ignored
            drive(9'(v), r, 1'b0, s[0], r[3]);
            // R4 R5 R6: check role with both bus values
            drive(9'(v), r ^ CW'(v), 1'b1, s[0], 1'b0);
            drive(9'(v), r ^ CW'(v), 1'b1, s[0], 1'b1);
         end
      end
      repeat (2) @(posedge clk);
      @(negedge clk);
      #1;
      if (q.size() != 0) begin
         errors++;
         $display("FAIL queue actual=%0d expected=0 pending items", q.size());
      end
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      done = 1;
      $finish;
   end

endmodule